// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Wake-Up Filter

The block receives asynchronous serial frames on one input line and presents them through a small register port with control, status and receive-data registers, plus a receive-full interrupt and a receive-error interrupt. Bit timing comes from a fixed clock divider that produces a 16x oversampling tick. Each bit is sampled once, near its middle. In multiprocessor format each frame carries one extra bit after the data. A value of 1 marks the frame as an address and 0 marks it as data.

Software can arm a wake-up filter so that a station on a shared line sleeps through traffic meant for other stations. While the filter is armed and in effect, data frames are dropped completely. A dropped frame loads no data, sets no flag and raises no interrupt. The first address frame is accepted normally, sets the status copy of the multiprocessor bit and disarms the filter in hardware. Software then reads the address and decides whether to keep listening or to re-arm the filter.

Top module: `mp_wake_rx`

## Requirements
- R1: After reset, the control register (address 0), the status register (address 1) and the data register (address 2) all read 0, and both interrupt outputs are 0. Address 3 reads 0.
- R2: A frame is one low start bit, then 8 data bits sent LSB first, then the multiprocessor bit only when control bit 1 (multiprocessor format) is 1, then one stop bit. An accepted frame with the receive-full flag at 0 loads the data register (bits 7:0 of address 2) and sets the receive-full flag (status bit 0).
- R3: The wake-up filter is in effect only when control bit 2 (filter arm) is 1, control bit 1 is 1 and control bit 0 (clocked-mode select) is 0. In any other case the arm bit has no effect on reception.
- R4: While the filter is in effect, a frame whose multiprocessor bit is 0 leaves the data register unchanged. It sets none of receive-full, framing error (status bit 1) or overrun (status bit 2), even with a bad stop bit or with receive-full already at 1, and it raises no interrupt.
- R5: While the filter is in effect, a frame whose multiprocessor bit is 1 is accepted, sets status bit 3 to 1 and clears control bit 2 in hardware. After the arm bit is cleared by hardware or by a software write of 0, flags and interrupts work normally.
- R6: In multiprocessor format, status bit 3 takes the multiprocessor bit of every accepted frame. Frames without that bit leave it unchanged, and it cannot be written.
- R7: An accepted frame whose stop bit is sampled as 0 sets the framing-error flag, and its data is still transferred.
- R8: An accepted frame that completes while receive-full is 1 sets the overrun flag and leaves the data register and receive-full unchanged.
- R9: Writing 0 to status bits 0, 1 or 2 clears that flag, and writing 1 leaves it unchanged. Reading the data register does not clear receive-full.
- R10: The receive-full interrupt is receive-full AND control bit 3 (receive interrupt enable). The error interrupt is (framing error OR overrun) AND control bit 3.
- R11: When a frame completes in the same cycle as a register write, overrun and filtering are decided on the register values before the write. A flag set by the frame survives a clear written in that cycle, and the hardware disarm takes priority over a written arm bit of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| rxi_o | output | 1 | Receive-full interrupt |
| eri_o | output | 1 | Receive-error interrupt |

## Verification
Two things can happen in the same clock: frame completion updates the status flags and the arm bit, and a software write targets the same register. The bench first measures, on a clean frame, how many cycles pass from the start of the stop bit to the rise of the receive-full interrupt. It then times register writes to land exactly on that edge in three cases: clearing receive-full while an overrun frame completes, clearing framing error while a bad-stop frame completes, and writing the arm bit as 1 while an address frame disarms it. The behavioural reference model applies the pre-write decision rule and the set-beats-clear rule, and the register read-back after each frame is compared with it.

// File: rtl/mp_wake_rx_pkg.sv
package mp_wake_rx_pkg;

  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  // control register, bit 3 down to bit 0
  typedef struct packed {
    logic rx_ie;
    logic wake_arm;
    logic mp_fmt;
    logic sync_sel;
  } ctrl_t;

  // status register, bit 3 down to bit 0
  typedef struct packed {
    logic mpb;
    logic ore;
    logic fer;
    logic full;
  } stat_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP
  } rx_state_e;

endpackage

// File: rtl/mp_wake_rx_tick.sv
module mp_wake_rx_tick #(
  parameter int unsigned CLK_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic rxd_o,
  output logic tick_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  assign rxd_o = sync_q[1];

  generate
    if (CLK_DIV > 1) begin : g_div
      localparam int unsigned CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      p_tick_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end else begin : g_nodiv
      assign tick_o = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/mp_wake_rx_deframe.sv
module mp_wake_rx_deframe
  import mp_wake_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              mp_fmt_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mpb_o,
  output logic              stop_ok_o,
  output logic              has_mp_o
);

  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned IW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] MID_START = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] MID_BIT   = CW'(OVS - 1);

  rx_state_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] shr_q;
  logic              mpb_q, has_mp_q, vld_q, stop_q;
  logic              bit_mid, last_bit;

  assign bit_mid  = (cnt_q == MID_BIT);
  assign last_bit = has_mp_q ? (idx_q == IW'(DATA_W)) : (idx_q == IW'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      shr_q    <= '0;
      mpb_q    <= 1'b0;
      has_mp_q <= 1'b0;
      vld_q    <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          ST_IDLE: begin
            if (!rxd_i) begin
              st_q     <= ST_START;
              cnt_q    <= '0;
              mpb_q    <= 1'b0;
              has_mp_q <= mp_fmt_i;
            end
          end
          ST_START: begin
            if (cnt_q == MID_START) begin
              cnt_q <= '0;
              idx_q <= '0;
              st_q  <= rxd_i ? ST_IDLE : ST_BITS;  // glitch rejection
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_BITS: begin
            if (bit_mid) begin
              cnt_q <= '0;
              idx_q <= idx_q + 1'b1;
              if (idx_q < IW'(DATA_W)) shr_q <= {rxd_i, shr_q[DATA_W-1:1]};
              else                     mpb_q <= rxd_i;
              if (last_bit) st_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (bit_mid) begin
              cnt_q  <= '0;
              vld_q  <= 1'b1;
              stop_q <= rxd_i;
              st_q   <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign vld_o     = vld_q;
  assign data_o    = shr_q;
  assign mpb_o     = mpb_q;
  assign stop_ok_o = stop_q;
  assign has_mp_o  = has_mp_q;

  p_frame_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);

  p_no_mpb_without_fmt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !has_mp_o) |-> !mpb_o);

endmodule

// File: rtl/mp_wake_rx_regs.sv
module mp_wake_rx_regs
  import mp_wake_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              frm_vld_i,
  input  logic [DATA_W-1:0] frm_data_i,
  input  logic              frm_mpb_i,
  input  logic              frm_stop_ok_i,
  input  logic              frm_has_mp_i,
  output logic              mp_fmt_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rxi_o,
  output logic              eri_o
);

  ctrl_t             ctrl_q;
  stat_t             stat_q;
  logic [DATA_W-1:0] data_q;

  logic       filt_on, drop, accept, wake, wr_ctrl, wr_stat;
  logic [2:0] clr;
  logic       unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:4];

  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_stat = we_i && (addr_i == ADDR_STAT);
  assign clr     = wr_stat ? ~wdata_i[2:0] : 3'b000;

  assign filt_on = ctrl_q.wake_arm && ctrl_q.mp_fmt && !ctrl_q.sync_sel;
  assign drop    = frm_vld_i && filt_on && !frm_mpb_i;
  assign accept  = frm_vld_i && !drop;
  assign wake    = accept && filt_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[3:0]);
      if (wake)    ctrl_q.wake_arm <= 1'b0;  // hardware disarm beats write
    end
  end

  // flags: set by frame beats clear by write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      data_q <= '0;
    end else begin
      stat_q.full <= (stat_q.full & ~clr[0]) | (accept & ~stat_q.full);
      stat_q.fer  <= (stat_q.fer  & ~clr[1]) | (accept & ~frm_stop_ok_i);
      stat_q.ore  <= (stat_q.ore  & ~clr[2]) | (accept &  stat_q.full);
      if (accept && frm_has_mp_i)  stat_q.mpb <= frm_mpb_i;
      if (accept && !stat_q.full)  data_q     <= frm_data_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      ADDR_CTRL: rdata_o[3:0] = ctrl_q;
      ADDR_STAT: rdata_o[3:0] = stat_q;
      ADDR_DATA: rdata_o      = data_q;
      default:   rdata_o      = '0;
    endcase
  end

  assign mp_fmt_o = ctrl_q.mp_fmt;
  assign rxi_o    = stat_q.full & ctrl_q.rx_ie;
  assign eri_o    = (stat_q.fer | stat_q.ore) & ctrl_q.rx_ie;

  p_filter_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && !(ctrl_q.wake_arm && ctrl_q.mp_fmt && !ctrl_q.sync_sel) && !stat_q.full)
      |=> stat_q.full);

  p_drop_silent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop && !we_i) |=> ($stable(stat_q) && $stable(data_q)));

  p_wake_disarm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake |=> (!ctrl_q.wake_arm && stat_q.mpb));

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !stat_q.full) |=> (stat_q.full && data_q == $past(frm_data_i)));

  p_fer_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !frm_stop_ok_i) |=> stat_q.fer);

  p_ovr_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && stat_q.full) |=> ($stable(data_q) && stat_q.ore));

endmodule

// File: rtl/mp_wake_rx.sv
module mp_wake_rx
  import mp_wake_rx_pkg::*;
#(
  parameter int unsigned CLK_DIV = 8,
  parameter int unsigned OVS     = 16,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rxi_o,
  output logic              eri_o
);

  logic              rxd_s, tick;
  logic              frm_vld, frm_mpb, frm_stop_ok, frm_has_mp, mp_fmt;
  logic [DATA_W-1:0] frm_data;

  mp_wake_rx_tick #(
    .CLK_DIV(CLK_DIV)
  ) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rxd_i (rxd_i),
    .rxd_o (rxd_s),
    .tick_o(tick)
  );

  mp_wake_rx_deframe #(
    .DATA_W(DATA_W),
    .OVS   (OVS)
  ) u_deframe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .rxd_i    (rxd_s),
    .mp_fmt_i (mp_fmt),
    .vld_o    (frm_vld),
    .data_o   (frm_data),
    .mpb_o    (frm_mpb),
    .stop_ok_o(frm_stop_ok),
    .has_mp_o (frm_has_mp)
  );

  mp_wake_rx_regs #(
    .DATA_W(DATA_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .frm_vld_i    (frm_vld),
    .frm_data_i   (frm_data),
    .frm_mpb_i    (frm_mpb),
    .frm_stop_ok_i(frm_stop_ok),
    .frm_has_mp_i (frm_has_mp),
    .mp_fmt_o     (mp_fmt),
    .rdata_o      (rdata_o),
    .rxi_o        (rxi_o),
    .eri_o        (eri_o)
  );

endmodule

// File: tb/mp_wake_rx_test.sv
module mp_wake_rx_test;

  localparam int T = 4;
  localparam int P = 16 * T;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       rxi, eri;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int off = -1;
  bit settling = 1'b0;
  bit done = 1'b0;

  // reference model state
  bit [3:0] m_ctrl = 4'd0;
  bit       m_full = 0, m_fer = 0, m_ore = 0, m_mpb = 0;
  bit [7:0] m_data = 8'd0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mp_wake_rx #(.CLK_DIV(T), .OVS(16), .DATA_W(8)) uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .rxd_i  (rxd),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .rxi_o  (rxi),
    .eri_o  (eri)
  );

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // interrupts compared with the model on every clock outside frame completion windows (R10)
  always @(negedge clk) begin
    #2;
    if (rst_n && !settling && !done) begin
      chk("R10 rxi", {7'd0, rxi}, {7'd0, m_full & m_ctrl[3]});
      chk("R10 eri", {7'd0, eri}, {7'd0, (m_fer | m_ore) & m_ctrl[3]});
    end
  end

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic chk_regs(input string req);
    rd(2'd0, {4'd0, m_ctrl}, {req, " ctrl"});
    rd(2'd1, {4'd0, m_mpb, m_ore, m_fer, m_full}, {req, " stat"});
    rd(2'd2, m_data, {req, " data"});
  endtask

  task automatic m_write(input logic [1:0] a, input logic [7:0] d);
    if (a == 2'd0) m_ctrl = d[3:0];
    if (a == 2'd1) begin
      m_full &= d[0];
      m_fer  &= d[1];
      m_ore  &= d[2];
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    m_write(a, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  // frame effect, decided on the register values before any same-cycle write
  task automatic m_frame(input bit [7:0] d, input bit mpb, input bit stop_ok, input bit has_mp,
                         input bit col, input logic [1:0] ca, input logic [7:0] cw);
    bit eff, old_full;
    eff      = m_ctrl[2] & m_ctrl[1] & ~m_ctrl[0];
    old_full = m_full;
    if (col) m_write(ca, cw);
    if (!(eff && !mpb)) begin
      if (eff) m_ctrl[2] = 1'b0;
      if (has_mp) m_mpb = mpb;
      if (old_full) m_ore = 1'b1;
      else begin
        m_data = d;
        m_full = 1'b1;
      end
      if (!stop_ok) m_fer = 1'b1;
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (P) @(negedge clk);
  endtask

  task automatic send(input bit [7:0] d, input bit mpb, input bit stop_b,
                      input bit col, input logic [1:0] ca, input logic [7:0] cw);
    bit has_mp, prev;
    int stop0;
    has_mp = m_ctrl[1];
    @(negedge clk);
    while (cyc % T != 0) @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (has_mp) drive_bit(mpb);
    rxd = stop_b;
    settling = 1'b1;
    stop0 = cyc;
    prev = rxi;
    for (int k = 0; k < P; k++) begin
      if (col && off > 0 && cyc == stop0 + off - 1) begin
        we = 1'b1; addr = ca; wdata = cw;
      end
      @(negedge clk);
      we = 1'b0;
      if (off < 0 && rxi && !prev) off = cyc - stop0;
      prev = rxi;
    end
    rxd = 1'b1;
    m_frame(d, mpb, stop_b, has_mp, col, ca, cw);
    settling = 1'b0;
    repeat (P) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk_regs("R1");
    rd(2'd3, 8'd0, "R1 unused addr");
    chk("R1 irq", {6'd0, rxi, eri}, 8'd0);

    // R2 plain frame, no multiprocessor bit; also calibrates completion offset
    wr(2'd0, 8'h08);
    send(8'hA5, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    chk_regs("R2 plain frame");
    chk("R10 rxi after frame", {7'd0, rxi}, 8'd1);
    chk("R11 calibration", {7'd0, off > 0}, 8'd1);
    rd(2'd2, 8'hA5, "R9 second data read");
    rd(2'd1, 8'h01, "R9 full kept after read");
    wr(2'd1, 8'h0E);
    chk_regs("R9 write 0 clears full");

    // R7 framing error
    send(8'h3C, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
    chk_regs("R7 bad stop");
    chk("R10 eri on fer", {7'd0, eri}, 8'd1);
    wr(2'd1, 8'h00);

    // R8 overrun
    send(8'h11, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    send(8'h22, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    chk_regs("R8 overrun");
    wr(2'd1, 8'h01);
    chk_regs("R9 write 1 keeps full");
    wr(2'd1, 8'h00);

    // R6 multiprocessor bit copy
    wr(2'd0, 8'h0A);
    send(8'h55, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    chk_regs("R6 mpb 0");
    wr(2'd1, 8'h00);
    send(8'h66, 1'b1, 1'b1, 1'b0, 2'd0, 8'd0);
    chk_regs("R6 mpb 1");
    wr(2'd1, 8'h00);
    chk_regs("R6 mpb not writable");

    // R4 armed filter drops data frames
    wr(2'd0, 8'h0E);
    send(8'h77, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    chk_regs("R4 data frame dropped");
    send(8'h78, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
    chk_regs("R4 bad stop dropped");

    // R5 address frame wakes and disarms
    send(8'h81, 1'b1, 1'b1, 1'b0, 2'd0, 8'd0);
    chk_regs("R5 address accepted");
    rd(2'd0, 8'h0A, "R5 arm cleared");

    // R4 no overrun from dropped frame while full
    wr(2'd0, 8'h0E);
    send(8'h90, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    chk_regs("R4 no overrun when dropped");

    // R5 software disarm restores normal handling
    wr(2'd0, 8'h0A);
    send(8'h91, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    chk_regs("R5 after software disarm");
    wr(2'd1, 8'h00);

    // R3 filter inert in clocked mode and without multiprocessor format
    wr(2'd0, 8'h0F);
    send(8'h12, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    chk_regs("R3 clocked-mode select");
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h0C);
    send(8'h13, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    chk_regs("R3 no mp format");
    wr(2'd1, 8'h00);

    // R11 collisions on the completion edge
    wr(2'd0, 8'h08);
    send(8'h40, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    send(8'h41, 1'b0, 1'b1, 1'b1, 2'd1, 8'h06);
    chk_regs("R11 clear full vs overrun");
    wr(2'd1, 8'h00);
    send(8'h42, 1'b0, 1'b0, 1'b1, 2'd1, 8'h0D);
    chk_regs("R11 fer set beats clear");
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h0E);
    send(8'h43, 1'b1, 1'b1, 1'b1, 2'd0, 8'h0E);
    chk_regs("R11 disarm beats write");

    done = 1'b1;
    repeat (4) @(negedge clk);
    finish_sim();
  end

endmodule